// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a successive-approximation conversion of a configurable width (10 bits by default). It steps a trial code that goes out to an external DAC and reads back a single comparator decision. It also drives the switch that links the holding capacitor to the analog input, and it keeps the last finished result in a register. Every step of the conversion is paced by a conversion clock. That clock comes either from the system clock through a power-of-two divider or from an enable strobe that an internal RC oscillator supplies in the system clock domain.

Software starts a conversion by setting the go bit and can cancel one by clearing it. A cancelled conversion never touches the result. The block then waits a two-period recovery gap and reconnects the input without further help. A finished conversion raises a sticky done flag, and that flag can drive an interrupt line.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `sample_en` is 1 and `dac_code`, `result`, `go_bit`, `done_flag` and `irq` are all 0.
- R2: The trial code starts with only the MSB set. On each conversion tick the bit under test is kept when `cmp_in` is 1 (input at or above the DAC level) and cleared when it is 0, and the next lower bit is then set. With an ideal comparator the final result equals the input level.
- R3: A `go_set` pulse while idle sets `go_bit` and opens the sample switch (`sample_en` = 0) on the next edge.
- R4: A conversion takes 11 conversion periods: one to align to the tick, then one per result bit from the MSB down. On the final tick, in the same edge, `result` is loaded, `go_bit` clears, `done_flag` sets and `sample_en` returns to 1.
- R5: `clk_sel` picks the divider as 2^(2*clk_sel[1:0] + clk_sel[2] + 1), giving 000=/2, 100=/4, 001=/8, 101=/16, 010=/32, 110=/64. Any code with clk_sel[1:0]=11 uses `rc_tick` as the conversion tick.
- R6: A `go_clr` pulse during a conversion aborts it. `go_bit` clears at once and `result` keeps the value of the last completed conversion.
- R7: After an abort, `sample_en` stays 0 for two conversion ticks and then returns to 1 without software action.
- R8: `irq` is high exactly when `done_flag` and `irq_en` are both high.
- R9: `done_flag` stays set until a `done_clr` pulse clears it.
- R10: A `go_set` pulse while a conversion or an abort recovery is in progress is ignored.
- R11: `clk_sel` is sampled only while idle. A change during a conversion does not alter that conversion's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_tick | input | 1 | One-cycle enable strobe from the RC oscillator |
| clk_sel | input | 3 | Conversion clock select |
| go_set | input | 1 | Software strobe that sets the go bit |
| go_clr | input | 1 | Software strobe that clears the go bit (abort) |
| done_clr | input | 1 | Software strobe that clears the done flag |
| irq_en | input | 1 | Interrupt enable |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | W | Trial code to the DAC |
| sample_en | output | 1 | 1 closes the sample switch |
| go_bit | output | 1 | Conversion in progress |
| result | output | W | Last completed result |
| done_flag | output | 1 | Sticky conversion-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit decision or a bad pointer shift shows up as a wrong `result` on the edge where `go_bit` falls, which is no later than eleven conversion periods after the start. A divider decoded wrongly moves that falling edge outside the window of 10N to 11N cycles for the selected divisor N. A recovery state that is stuck or cut short shows at `sample_en`, which must return within two ticks after an abort. A stray update on abort leaves a mismatched `result` that can be seen right after the `go_clr` pulse.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SYNC = 2'd1,
      ST_CONV = 2'd2,
      ST_REC  = 2'd3
   } sar_state_e;

   localparam int DIV_LG_MAX = 6;

   // log2 of the divider for a select code; RC codes return 1 (unused)
   function automatic logic [2:0] div_lg(input logic [2:0] sel);
      if (sel[1:0] == 2'b11) return 3'd1;
      return {sel[1:0], 1'b0} + {2'b00, sel[2]} + 3'd1;
   endfunction

endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen
   import sar_pkg::*;
#(
   parameter int CNT_W  = DIV_LG_MAX,
   parameter bit USE_RC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rc_tick,
   input  logic [2:0] sel,
   output logic       tad
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;
   logic [2:0]       lg;
   logic             div_tick;
   logic             is_rc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   always_comb begin
      lg       = div_lg(sel);
      mask     = ~({CNT_W{1'b1}} << lg);
      div_tick = ((cnt & mask) == mask);
      is_rc    = (sel[1:0] == 2'b11);
   end

   generate
      if (USE_RC) begin : g_rc
         assign tad = is_rc ? rc_tick : div_tick;
      end else begin : g_no_rc
         logic unused_rc;
         assign unused_rc = rc_tick ^ is_rc;
         assign tad       = div_tick;
      end
   endgenerate

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic         step,
   input  logic         cmp,
   output logic [W-1:0] trial,
   output logic [W-1:0] resolved,
   output logic         last
);

   localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] ptr;

   assign resolved = cmp ? trial : (trial & ~ptr);
   assign last     = ptr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial <= '0;
         ptr   <= '0;
      end else if (clr) begin
         trial <= '0;
         ptr   <= '0;
      end else if (load) begin
         trial <= MSB_ONE;
         ptr   <= MSB_ONE;
      end else if (step) begin
         trial <= resolved | (ptr >> 1);
         ptr   <= ptr >> 1;
      end
   end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_pkg::*;
#(
   parameter int W        = 10,
   parameter int REC_TADS = 2,
   parameter bit USE_RC   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rc_tick,
   input  logic [2:0]   clk_sel,
   input  logic         go_set,
   input  logic         go_clr,
   input  logic         done_clr,
   input  logic         irq_en,
   input  logic         cmp_in,
   output logic [W-1:0] dac_code,
   output logic         sample_en,
   output logic         go_bit,
   output logic [W-1:0] result,
   output logic         done_flag,
   output logic         irq
);

   localparam int REC_W = $clog2(REC_TADS + 1);
   localparam logic [REC_W-1:0] REC_LAST = REC_W'(REC_TADS - 1);

   generate
      if (W < 2)        begin : g_bad_w   $error("W must be at least 2");        end
      if (REC_TADS < 1) begin : g_bad_rec $error("REC_TADS must be at least 1"); end
   endgenerate

   sar_state_e       state;
   logic [2:0]       sel_q;
   logic [REC_W-1:0] rec_cnt;
   logic             tad;
   logic             start_conv, step, finish, abort, clr;
   logic [W-1:0]     resolved;
   logic             last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sel_q <= 3'b000;
      else if (state == ST_IDLE) sel_q <= clk_sel;
   end

   sar_tad_gen #(.CNT_W(DIV_LG_MAX), .USE_RC(USE_RC)) i_tad (
      .clk     (clk),
      .rst_n   (rst_n),
      .rc_tick (rc_tick),
      .sel     (sel_q),
      .tad     (tad)
   );

   always_comb begin
      abort      = go_bit && go_clr;
      start_conv = (state == ST_SYNC) && tad && !go_clr;
      step       = (state == ST_CONV) && tad && !go_clr;
      finish     = step && last;
      clr        = abort || finish;
   end

   sar_approx_reg #(.W(W)) i_sar (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load     (start_conv),
      .step     (step),
      .cmp      (cmp_in),
      .trial    (dac_code),
      .resolved (resolved),
      .last     (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         go_bit  <= 1'b0;
         rec_cnt <= '0;
         result  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (go_set) begin
                  go_bit <= 1'b1;
                  state  <= ST_SYNC;
               end
            end
            ST_SYNC, ST_CONV: begin
               if (abort) begin
                  go_bit  <= 1'b0;
                  rec_cnt <= '0;
                  state   <= ST_REC;
               end else if (start_conv) begin
                  state <= ST_CONV;
               end else if (finish) begin
                  result <= resolved;
                  go_bit <= 1'b0;
                  state  <= ST_IDLE;
               end
            end
            ST_REC: begin
               if (tad) begin
                  if (rec_cnt == REC_LAST) state <= ST_IDLE;
                  rec_cnt <= rec_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_flag <= 1'b0;
      else if (finish)   done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;
   end

   assign sample_en = (state == ST_IDLE);
   assign irq       = done_flag && irq_en;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int W = 10
) (
   input logic         clk,
   input logic         rst_n,
   input logic         go_set,
   input logic         go_clr,
   input logic         done_clr,
   input logic         irq_en,
   input logic         go_bit,
   input logic         sample_en,
   input logic         done_flag,
   input logic         irq,
   input logic [W-1:0] result
);

   AST_OPEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      go_bit |-> !sample_en) else $error("switch closed while busy"); // R3

   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_bit && sample_en && go_set) |=> go_bit) else $error("start lost"); // R3

   AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> $fell(go_bit)) else $error("done without go clear"); // R4

   AST_RESULT_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> ($fell(go_bit) && done_flag)) else $error("stray result update"); // R6

   AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (go_bit && go_clr) |=> (!go_bit && !sample_en)) else $error("abort ignored"); // R7

   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done_flag && irq_en)) else $error("spurious irq"); // R8

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !done_clr) |=> done_flag) else $error("done dropped"); // R9

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.W(W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .go_set    (go_set),
   .go_clr    (go_clr),
   .done_clr  (done_clr),
   .irq_en    (irq_en),
   .go_bit    (go_bit),
   .sample_en (sample_en),
   .done_flag (done_flag),
   .irq       (irq),
   .result    (result)
);

// File: tb/test_sar_conv_seq.sv
`timescale 1ns/1ps
module test_sar_conv_seq;

   localparam int W      = 10;
   localparam int RC_PER = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rc_tick = 1'b0;
   logic [2:0]   clk_sel = 3'b000;
   logic         go_set = 1'b0, go_clr = 1'b0, done_clr = 1'b0, irq_en = 1'b0;
   logic         cmp_in;
   logic [W-1:0] dac_code, result;
   logic         sample_en, go_bit, done_flag, irq;
   int           vin = 0;
   int           checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   // ideal comparator and DAC
   assign cmp_in = (vin >= int'(dac_code));

   sar_conv_seq #(.W(W)) i_sar_conv_seq (
      .clk(clk), .rst_n(rst_n), .rc_tick(rc_tick), .clk_sel(clk_sel),
      .go_set(go_set), .go_clr(go_clr), .done_clr(done_clr), .irq_en(irq_en),
      .cmp_in(cmp_in), .dac_code(dac_code), .sample_en(sample_en), .go_bit(go_bit),
      .result(result), .done_flag(done_flag), .irq(irq)
   );

   initial begin
      forever begin
         repeat (RC_PER - 1) @(negedge clk);
         rc_tick = 1'b1;
         @(negedge clk);
         rc_tick = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int divisor(input logic [2:0] s);
      if (s[1:0] == 2'b11) return RC_PER;
      return 1 << (2 * int'(s[1:0]) + int'(s[2]) + 1);
   endfunction

   // kind: 0 none, 1 extra go_set, 2 select change to 000
   task automatic run_conv(input logic [2:0] s, input int v, input int kind,
                           input int mid_at, output int cyc);
      @(negedge clk);
      clk_sel = s;
      vin     = v;
      go_set  = 1'b1;
      @(negedge clk);
      go_set = 1'b0;
      cyc    = 1;
      while (go_bit) begin
         @(negedge clk);
         cyc++;
         if (cyc == mid_at && kind == 1) go_set = 1'b1;
         if (cyc == mid_at && kind == 2) clk_sel = 3'b000;
         if (cyc == mid_at + 1) go_set = 1'b0;
      end
   endtask

   task automatic chk_span(input string req, input int cyc, input int n);
      chk(cyc > 10 * n && cyc <= 11 * n + 2, req, cyc, 11 * n);
   endtask

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(sample_en == 1'b1, "R1 sample_en", int'(sample_en), 1);
      chk(go_bit == 1'b0 && done_flag == 1'b0 && irq == 1'b0, "R1 flags",
          int'({go_bit, done_flag, irq}), 0);
      chk(result == '0 && dac_code == '0, "R1 result/dac", int'(result), 0);

      // R2 exhaustive sweep at Fosc/2
      for (int v = 0; v < (1 << W); v++) begin
         run_conv(3'b000, v, 0, 0, c);
         chk(int'(result) == v, "R2 result", int'(result), v);
      end

      // R4 completion state and span
      run_conv(3'b000, 517, 0, 0, c);
      chk_span("R4 span", c, 2);
      chk(done_flag && sample_en && !go_bit && dac_code == '0, "R4 end state",
          int'({done_flag, sample_en, go_bit}), 6);

      // R5 every select code
      for (int s = 0; s < 8; s++) begin
         run_conv(3'(s), 677 - s, 0, 0, c);
         chk_span("R5 span", c, divisor(3'(s)));
         chk(int'(result) == 677 - s, "R5 result", int'(result), 677 - s);
      end

      // R8 / R9 done flag and interrupt
      irq_en = 1'b0;
      @(negedge clk);
      chk(irq == 1'b0, "R8 masked", int'(irq), 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk(irq == 1'b1, "R8 enabled", int'(irq), 1);
      repeat (20) @(negedge clk);
      chk(done_flag == 1'b1, "R9 sticky", int'(done_flag), 1);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk(done_flag == 1'b0 && irq == 1'b0, "R9 cleared", int'(done_flag), 0);
      repeat (10) @(negedge clk);
      chk(done_flag == 1'b0, "R9 stays clear", int'(done_flag), 0);
      irq_en = 1'b0;

      // R3 start opens the switch
      @(negedge clk);
      clk_sel = 3'b001;
      vin     = 100;
      go_set  = 1'b1;
      @(negedge clk);
      go_set = 1'b0;
      chk(go_bit == 1'b1 && sample_en == 1'b0, "R3 start", int'({go_bit, sample_en}), 2);
      while (go_bit) @(negedge clk);
      chk(int'(result) == 100, "R3 result", int'(result), 100);

      // R10 extra start during conversion is ignored
      run_conv(3'b100, 300, 1, 15, c);
      chk_span("R10 span", c, 4);
      chk(int'(result) == 300, "R10 result", int'(result), 300);

      // R11 select change mid-conversion
      run_conv(3'b101, 801, 2, 20, c);
      chk_span("R11 span", c, 16);
      chk(int'(result) == 801, "R11 result", int'(result), 801);

      // R6 / R7 abort and recovery at Fosc/8
      @(negedge clk);
      clk_sel = 3'b001;
      vin     = 900;
      go_set  = 1'b1;
      @(negedge clk);
      go_set = 1'b0;
      repeat (30) @(negedge clk);
      go_clr = 1'b1;
      @(negedge clk);
      go_clr = 1'b0;
      chk(go_bit == 1'b0, "R6 go cleared", int'(go_bit), 0);
      chk(int'(result) == 801, "R6 result kept", int'(result), 801);
      chk(sample_en == 1'b0, "R7 gap open", int'(sample_en), 0);
      begin
         int k = 1;
         bit go_seen = 1'b0;
         while (!sample_en) begin
            @(negedge clk);
            k++;
            if (k == 2) go_set = 1'b1;
            if (k == 3) go_set = 1'b0;
            if (go_bit) go_seen = 1'b1;
         end
         chk(k >= 9 && k <= 18, "R7 recovery", k, 16);
         chk(!go_seen && !go_bit, "R10 start in recovery", int'(go_seen), 0);
      end
      chk(int'(result) == 801, "R6 result after gap", int'(result), 801);
      run_conv(3'b001, 900, 0, 0, c);
      chk(int'(result) == 900, "R7 restart", int'(result), 900);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule